// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits between a single bus master and a downstream memory port and assigns each access a security verdict. When the master presents a request, the filter compares three things: the exempt and non-secure flags that an external attribution lookup returns for the request address, and two static configuration inputs. The first input says whether the master is treated as non-secure. The second picks how a refused access is answered. The verdict is one of four: forward marked secure, forward marked non-secure, refuse with a quiet read-as-zero/write-dropped answer, or refuse with an error answer.

Forwarded requests go downstream unchanged, with the secure attribute replaced by the filter's verdict. The downstream response passes straight back to the master. Refused requests never reach the downstream port. A refusal answered with an error also raises a sticky level interrupt. A level-held clear input both empties the interrupt status and blocks it from being set.

The control is a four-state machine. IDLE accepts a request and decides. ISSUE holds the downstream request until it is taken. AWAIT passes the downstream response through. REFUSE answers a refused access on its own. The transitions are: IDLE→ISSUE (forward verdict), IDLE→REFUSE (refused verdict), ISSUE→AWAIT (downstream ready), AWAIT→IDLE (downstream response), and REFUSE→IDLE (always, after one cycle).

Top module: `mst_sec_filter`

## Requirements
- R1: If the lookup flags the address as exempt, the access is forwarded. Its secure attribute is 1 when `cfg_master_ns` is low and 0 when it is high, whatever the non-secure flag says.
- R2: If the address is not exempt and the lookup flags it non-secure, the access is forwarded with the secure attribute 0.
- R3: If the address is neither exempt nor non-secure and `cfg_master_ns` is low, the access is forwarded with the secure attribute 1.
- R4: If the address is neither exempt nor non-secure and `cfg_master_ns` is high, the access is refused and no downstream request is issued.
- R5: A refusal made while `cfg_err_resp` is low is answered in the cycle after acceptance with read data all zero and the error flag 0. A refused write changes nothing downstream.
- R6: A refusal made while `cfg_err_resp` is high is answered in the cycle after acceptance with the error flag 1.
- R7: An error-answered refusal sets the interrupt status at its acceptance edge, unless `irq_clr` is high in that cycle. A quiet refusal never sets it.
- R8: While `irq_clr` is high, the status is cleared at the next edge and stays clear. `irq` is the status bit.
- R9: For a forwarded access, address, write data, size code and write flag reach the downstream port unchanged. The size code is 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes, and byte k of the 64-bit data belongs to address+k.
- R10: After reset, `irq` is low, `up_req_ready` is high and `dn_req_valid` is low.
- R11: The verdict is formed from the inputs in the acceptance cycle. While a downstream request waits for ready, its fields and secure attribute stay stable.
- R12: For a forwarded access, downstream read data and error flag pass through to the upstream response in the cycle the downstream response arrives. `up_req_ready` stays low from acceptance until that response, so only one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master_ns | input | 1 | Master is treated as non-secure |
| cfg_err_resp | input | 1 | Refusals answered with error (1) or read-as-zero (0) |
| irq_clr | input | 1 | Level clear and suppress for the interrupt |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_addr | input | AW | Upstream address |
| up_wdata | input | DW | Upstream write data |
| up_size | input | 2 | Size code (bytes = 1 << code) |
| up_write | input | 1 | Write (1) or read (0) |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rdata | output | DW | Upstream read data |
| up_rsp_err | output | 1 | Upstream error flag |
| lk_addr | output | AW | Address presented to the attribution lookup |
| lk_exempt | input | 1 | Lookup: address exempt from checking |
| lk_ns | input | 1 | Lookup: address is non-secure |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_size | output | 2 | Downstream size code |
| dn_write | output | 1 | Downstream write flag |
| dn_secure | output | 1 | Downstream secure attribute |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rdata | input | DW | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error flag |
| irq | output | 1 | Sticky interrupt for error-answered refusals |

## Verification
Two functions can meet in one acceptance cycle: an error-answered refusal that would set the interrupt status, and a held `irq_clr` that would clear it. The bench provokes this by raising `irq_clr` in the same cycle it presents a refused access with `cfg_err_resp` high. The access must still get its error answer, and `irq` must stay low afterward. The next refusal without the clear must then raise `irq`. A second pair is a pulse on `irq_clr` while the status is already set. The clear is judged at the port one cycle later.

// File: rtl/mst_sec_filter_pkg.sv
package mst_sec_filter_pkg;

    typedef enum logic [1:0] {
        VD_ABORT  = 2'd0,
        VD_QUIET  = 2'd1,
        VD_FWD_S  = 2'd2,
        VD_FWD_NS = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_REFUSE = 2'd3
    } flt_state_e;

    localparam int SIZE_W = 2;

endpackage

// File: rtl/mst_sec_decide.sv
module mst_sec_decide
    import mst_sec_filter_pkg::*;
(
    input  logic     exempt,
    input  logic     addr_ns,
    input  logic     master_ns,
    input  logic     err_resp,
    output verdict_e verdict
);
    always_comb begin
        if (exempt) begin
            verdict = master_ns ? VD_FWD_NS : VD_FWD_S;
        end else if (addr_ns) begin
            verdict = VD_FWD_NS;
        end else if (!master_ns) begin
            verdict = VD_FWD_S;
        end else begin
            verdict = err_resp ? VD_ABORT : VD_QUIET;
        end
    end
endmodule

// File: rtl/mst_sec_irq.sv
module mst_sec_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_lvl,
    output logic status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (clr_lvl) begin
            status <= 1'b0;
        end else if (set_req) begin
            status <= 1'b1;
        end
    end
endmodule

// File: rtl/mst_sec_hold.sv
module mst_sec_hold
    import mst_sec_filter_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     addr_in,
    input  logic [DW-1:0]     wdata_in,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              write_in,
    input  verdict_e          verdict_in,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     wdata_q,
    output logic [SIZE_W-1:0] size_q,
    output logic              write_q,
    output verdict_e          verdict_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            size_q    <= '0;
            write_q   <= 1'b0;
            verdict_q <= VD_QUIET;
        end else if (load) begin
            addr_q    <= addr_in;
            wdata_q   <= wdata_in;
            size_q    <= size_in;
            write_q   <= write_in;
            verdict_q <= verdict_in;
        end
    end
endmodule

// File: rtl/mst_sec_filter.sv
module mst_sec_filter
    import mst_sec_filter_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master_ns,
    input  logic              cfg_err_resp,
    input  logic              irq_clr,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [AW-1:0]     up_addr,
    input  logic [DW-1:0]     up_wdata,
    input  logic [SIZE_W-1:0] up_size,
    input  logic              up_write,
    output logic              up_rsp_valid,
    output logic [DW-1:0]     up_rdata,
    output logic              up_rsp_err,
    output logic [AW-1:0]     lk_addr,
    input  logic              lk_exempt,
    input  logic              lk_ns,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [AW-1:0]     dn_addr,
    output logic [DW-1:0]     dn_wdata,
    output logic [SIZE_W-1:0] dn_size,
    output logic              dn_write,
    output logic              dn_secure,
    input  logic              dn_rsp_valid,
    input  logic [DW-1:0]     dn_rdata,
    input  logic              dn_rsp_err,
    output logic              irq
);
    flt_state_e state_q, state_d;
    verdict_e   verdict_now, verdict_q;
    logic       accept;
    logic       forward_now;

    assign lk_addr     = up_addr;
    assign accept      = (state_q == ST_IDLE) && up_req_valid;
    assign forward_now = (verdict_now == VD_FWD_S) || (verdict_now == VD_FWD_NS);

    mst_sec_decide u_decide (
        .exempt    (lk_exempt),
        .addr_ns   (lk_ns),
        .master_ns (cfg_master_ns),
        .err_resp  (cfg_err_resp),
        .verdict   (verdict_now)
    );

    mst_sec_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .addr_in    (up_addr),
        .wdata_in   (up_wdata),
        .size_in    (up_size),
        .write_in   (up_write),
        .verdict_in (verdict_now),
        .addr_q     (dn_addr),
        .wdata_q    (dn_wdata),
        .size_q     (dn_size),
        .write_q    (dn_write),
        .verdict_q  (verdict_q)
    );

    mst_sec_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (accept && (verdict_now == VD_ABORT)),
        .clr_lvl (irq_clr),
        .status  (irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (up_req_valid) begin
                    state_d = forward_now ? ST_ISSUE : ST_REFUSE;
                end
            end
            ST_ISSUE: begin
                if (dn_req_ready) begin
                    state_d = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (dn_rsp_valid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_req_ready = 1'b0;
        dn_req_valid = 1'b0;
        up_rsp_valid = 1'b0;
        up_rdata     = '0;
        up_rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:  up_req_ready = 1'b1;
            ST_ISSUE: dn_req_valid = 1'b1;
            ST_AWAIT: begin
                up_rsp_valid = dn_rsp_valid;
                up_rdata     = dn_rdata;
                up_rsp_err   = dn_rsp_err;
            end
            ST_REFUSE: begin
                up_rsp_valid = 1'b1;
                up_rsp_err   = (verdict_q == VD_ABORT);
            end
            default: ;
        endcase
    end

    assign dn_secure = (verdict_q == VD_FWD_S);

endmodule

// File: rtl/mst_sec_filter_checker.sv
module mst_sec_filter_checker #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_master_ns,
    input logic          cfg_err_resp,
    input logic          irq_clr,
    input logic          up_req_valid,
    input logic          up_req_ready,
    input logic          up_rsp_valid,
    input logic [DW-1:0] up_rdata,
    input logic          up_rsp_err,
    input logic          lk_exempt,
    input logic          lk_ns,
    input logic          dn_req_valid,
    input logic          dn_req_ready,
    input logic [AW-1:0] dn_addr,
    input logic          dn_secure,
    input logic          irq
);
    logic acc;
    logic blk;
    assign acc = up_req_valid && up_req_ready;
    assign blk = acc && !lk_exempt && !lk_ns && cfg_master_ns;

    AST_EXEMPT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lk_exempt) |=> (dn_req_valid && (dn_secure == !$past(cfg_master_ns)))); // R1
    AST_NS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !lk_exempt && lk_ns) |=> (dn_req_valid && !dn_secure)); // R2
    AST_SEC_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !lk_exempt && !lk_ns && !cfg_master_ns) |=> (dn_req_valid && dn_secure)); // R3
    AST_BLOCK_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> !dn_req_valid); // R4
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cfg_err_resp) |=> (up_rsp_valid && !up_rsp_err && (up_rdata == '0))); // R5
    AST_ERR_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && cfg_err_resp) |=> (up_rsp_valid && up_rsp_err)); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && cfg_err_resp && !irq_clr) |=> irq); // R7
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq); // R8
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> ($stable(dn_addr) && $stable(dn_secure) && dn_req_valid)); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_ready |-> (!dn_req_valid && !up_rsp_valid)); // R12
endmodule

bind mst_sec_filter mst_sec_filter_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/mst_sec_filter_bench.sv
`timescale 1ns/1ps
module mst_sec_filter_bench;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam logic [1:0] O_ABT = 2'd0, O_RAZ = 2'd1, O_SEC = 2'd2, O_NS = 2'd3;

    typedef struct packed {
        logic        ex;
        logic        ns;
        logic        mns;
        logic        erq;
        logic        clr;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [1:0]  outc;
        logic        irq_after;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,32'h1000_0008,O_SEC,1'b0}, // R1
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,2'd2,32'h1000_0010,O_NS ,1'b0}, // R1
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h2000_0001,O_NS ,1'b0}, // R2
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,2'd1,32'h2000_0002,O_NS ,1'b0}, // R2
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd3,32'h3000_0000,O_SEC,1'b0}, // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,32'h3000_000F,O_SEC,1'b0}, // R3 R12
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,32'h4000_0000,O_RAZ,1'b0}, // R5
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd2,32'h4000_0004,O_RAZ,1'b0}, // R5
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,2'd2,32'h4000_0008,O_ABT,1'b0}, // R6 R7 suppressed
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'd0,32'h4000_000C,O_ABT,1'b1}, // R6 R7
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,2'd1,32'h5000_0000,O_NS ,1'b1}, // R1
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'd2,32'h4000_0010,O_RAZ,1'b1}, // R5 R7
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd3,32'h2000_000F,O_NS ,1'b1}  // R2 R12
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master_ns = 1'b0, cfg_err_resp = 1'b0, irq_clr = 1'b0;
    logic up_req_valid = 1'b0;
    logic up_req_ready;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic [1:0] up_size = '0;
    logic up_write = 1'b0;
    logic up_rsp_valid;
    logic [DW-1:0] up_rdata;
    logic up_rsp_err;
    logic [AW-1:0] lk_addr;
    logic lk_exempt = 1'b0, lk_ns = 1'b0;
    logic dn_req_valid;
    logic dn_req_ready;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic [1:0] dn_size;
    logic dn_write, dn_secure;
    logic dn_rsp_valid;
    logic [DW-1:0] dn_rdata;
    logic dn_rsp_err;
    logic irq;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    mst_sec_filter #(.AW(AW), .DW(DW)) u_mst_sec_filter (.*);

    // downstream model: ready one cycle after valid, response two cycles after handshake
    logic        seen;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_wdata;
    logic [1:0]  cap_size;
    logic        cap_write, cap_secure;
    int          rsp_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_req_ready <= 1'b0;
            dn_rsp_valid <= 1'b0;
            dn_rdata     <= '0;
            dn_rsp_err   <= 1'b0;
            rsp_cnt      <= 0;
            seen         <= 1'b0;
            cap_addr     <= '0;
            cap_wdata    <= '0;
            cap_size     <= '0;
            cap_write    <= 1'b0;
            cap_secure   <= 1'b0;
        end else begin
            dn_req_ready <= dn_req_valid && !dn_req_ready;
            dn_rsp_valid <= 1'b0;
            if (dn_req_valid && dn_req_ready) begin
                seen       <= 1'b1;
                cap_addr   <= dn_addr;
                cap_wdata  <= dn_wdata;
                cap_size   <= dn_size;
                cap_write  <= dn_write;
                cap_secure <= dn_secure;
                rsp_cnt    <= 2;
            end else if (rsp_cnt == 1) begin
                rsp_cnt      <= 0;
                dn_rsp_valid <= 1'b1;
                dn_rdata     <= {~cap_addr, cap_addr};
                dn_rsp_err   <= (cap_addr[3:0] == 4'hF);
            end else if (rsp_cnt > 1) begin
                rsp_cnt <= rsp_cnt - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic er;
        wd = {v.addr, ~v.addr};
        @(negedge clk);
        seen          = 1'b0;
        lk_exempt     = v.ex;
        lk_ns         = v.ns;
        cfg_master_ns = v.mns;
        cfg_err_resp  = v.erq;
        irq_clr       = v.clr;
        up_addr       = v.addr;
        up_wdata      = wd;
        up_size       = v.sz;
        up_write      = v.wr;
        up_req_valid  = 1'b1;
        chk(up_req_ready == 1'b1, "R12 ready before accept", {63'd0, up_req_ready}, 64'd1);
        @(negedge clk);
        up_req_valid = 1'b0;
        lk_exempt = ~v.ex; lk_ns = ~v.ns; cfg_master_ns = ~v.mns; // R11: later inputs must not matter
        chk(up_req_ready == 1'b0, "R12 busy after accept", {63'd0, up_req_ready}, 64'd0);
        while (!up_rsp_valid) @(negedge clk);
        rd = up_rdata;
        er = up_rsp_err;
        case (v.outc)
            O_ABT: begin
                chk(er == 1'b1, "R6 error answer", {63'd0, er}, 64'd1);
                chk(seen == 1'b0, "R4 no downstream", {63'd0, seen}, 64'd0);
            end
            O_RAZ: begin
                chk(rd == '0 && er == 1'b0, "R5 quiet answer", rd, 64'd0);
                chk(seen == 1'b0, "R4 R5 no downstream", {63'd0, seen}, 64'd0);
            end
            default: begin
                chk(seen == 1'b1, "R11 downstream issued", {63'd0, seen}, 64'd1);
                chk(cap_secure == (v.outc == O_SEC), "R1 R2 R3 secure attr",
                    {63'd0, cap_secure}, {63'd0, v.outc == O_SEC});
                chk(cap_addr == v.addr && cap_size == v.sz && cap_write == v.wr,
                    "R9 fields", {cap_addr, 28'd0, cap_write, 1'b0, cap_size}, {v.addr, 28'd0, v.wr, 1'b0, v.sz});
                chk(cap_wdata == wd, "R9 wdata", cap_wdata, wd);
                chk(rd == {~v.addr, v.addr}, "R12 rdata passthrough", rd, {~v.addr, v.addr});
                chk(er == (v.addr[3:0] == 4'hF), "R12 err passthrough", {63'd0, er}, {63'd0, v.addr[3:0] == 4'hF});
            end
        endcase
        @(negedge clk);
        chk(irq == v.irq_after, "R7 R8 irq after access", {63'd0, irq}, {63'd0, v.irq_after});
        irq_clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R10 irq after reset", {63'd0, irq}, 64'd0);
        chk(up_req_ready == 1'b1, "R10 ready after reset", {63'd0, up_req_ready}, 64'd1);
        chk(dn_req_valid == 1'b0, "R10 no dn valid in reset", {63'd0, dn_req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0 && up_req_ready == 1'b1, "R10 idle after release", {62'd0, irq, up_req_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            run_vec(VT[i]);
        end

        // R8: pulse clear while status set (irq is 1 after the table)
        chk(irq == 1'b1, "R8 precondition", {63'd0, irq}, 64'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R8 clear pulse", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk(irq == 1'b0, "R8 stays clear", {63'd0, irq}, 64'd0);

        // R7: set again, then R10 reset clears it
        run_vec('{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'd3,32'h4000_0020,O_ABT,1'b1});
        rst_n = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R10 reset clears irq", {63'd0, irq}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: quiet refusal after reset leaves irq low
        run_vec('{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'd1,32'h4000_0030,O_RAZ,1'b0});

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule